// File: doc/BRIEF.md
# Warp Issue Scheduler with Pipe and Queue Throttles

This block is the instruction issue stage of one GPU sub-partition. It watches a pool of up to sixteen resident warp slots. Each slot reports whether a warp is active, the operand-dependency state of its next instruction, and which execution resource that instruction needs: the FP32 multiply-add pipe, the special-function pipe, the memory request queue, or the double-precision pipe. Warps never migrate, so slot *i* always means the same warp.

Each cycle the scheduler works out which warps could issue. Among those it grants one in round-robin order, starting after the warp granted last. It also gives every warp a stall reason code that explains why it did not issue. The special-function and double-precision pipes can only accept a new instruction every few cycles, so the block keeps its own countdown for each. Busy status for the FP32 pipe and fullness of the memory request queue arrive as inputs.

Decode, operand tracking and execution sit outside this block. Their results arrive as the dependency and class inputs.

Top module: `warp_issue_sched`

## Requirements
- R1: While `rst` is high at a clock edge, `issue_grant` becomes all zeros, every stall code becomes 0, both pipe countdowns clear, and the round-robin pointer is set so that warp 0 has first priority on the first cycle after reset.
- R2: Inputs sampled at a clock edge produce `issue_grant` and `stall_code` right after that same edge. `issue_grant` has at most one bit set. Each grant lasts exactly one cycle per issue decision.
- R3: Dependency field per warp (2 bits): 0 = ready, 1 = short-latency dependency, 2 or 3 = long-latency dependency. An active warp with a nonzero dependency field is never granted. Its code is 1 (short) or 2 (long). Dependency takes precedence over every throttle.
- R4: Class 1 is the special-function pipe. Once a class-1 instruction issues at edge N, no class-1 instruction issues at edges N+1 to N+3, and one may issue at N+4 (interval `SFU_INTERVAL` = 4). A ready class-1 warp held back this way gets code 4.
- R5: Class 0 is the FP32 multiply-add pipe, which can accept one instruction every cycle. When `fma_pipe_busy` is high, ready class-0 warps are not granted and get code 4.
- R6: Class 2 is a memory operation. While `mem_q_full` is high, ready class-2 warps are not granted and get code 3. The FP32 pipe busy flag has no effect on them.
- R7: A warp that was eligible but lost to the granted warp gets code 5. The granted warp gets code 0.
- R8: Selection is round-robin. The search starts at the warp after the last granted one, wraps from warp 15 to warp 0, and leaves the pointer unchanged in cycles with no grant.
- R9: Warps whose `warp_active` bit is low are never granted and get code 0 whatever their other fields say.
- R10: Class 3 is the double-precision pipe, with an issue interval of `DP_INTERVAL` = 2 cycles. A ready class-3 warp held back gets code 4. This pipe's countdown is separate from the special-function pipe's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_active | input | 16 | One bit per warp slot: slot holds a live warp |
| warp_dep | input | 32 | 2 bits per warp, dependency state of next instruction |
| warp_cls | input | 32 | 2 bits per warp, resource class of next instruction |
| mem_q_full | input | 1 | Memory request queue cannot accept a request |
| fma_pipe_busy | input | 1 | FP32 multiply-add pipe cannot accept this cycle |
| issue_grant | output | 16 | Registered one-hot grant, zero when nothing issues |
| stall_code | output | 48 | 3 bits per warp: registered stall reason |

## Verification
The bench targets the points where the stall classes meet. One is a warp that has a dependency and would also be throttled; a design with the priority reversed reports a throttle code there. Another is a memory warp facing a full queue alongside free arithmetic pipes; a design that mixes up the pipes grants it or blocks the wrong warp. The countdown edges are checked one cycle at a time, with a single special-function warp and then a single double-precision warp. An off-by-one countdown grants one cycle early or late. The bench also checks pointer wrap from warp 15 to warp 0 and pointer recovery after a mid-run reset. A pointer that restarts at the granted warp, or skips one, grants the wrong slot.

// File: rtl/warp_sched_pkg.sv
`timescale 1ns/1ps
package warp_sched_pkg;

    // Resource class of a warp's next instruction
    typedef enum logic [1:0] {
        CL_FMA  = 2'd0,
        CL_SFU  = 2'd1,
        CL_MEM  = 2'd2,
        CL_DFMA = 2'd3
    } cls_e;

    localparam int NUM_CLS = 4;

    // Operand dependency state
    typedef enum logic [1:0] {
        DP_READY = 2'd0,
        DP_SHORT = 2'd1,
        DP_LONG  = 2'd2,
        DP_LONG2 = 2'd3
    } dep_e;

    // Per-warp stall reason
    typedef enum logic [2:0] {
        ST_NONE    = 3'd0,
        ST_SHORT   = 3'd1,
        ST_LONG    = 3'd2,
        ST_MEMTHR  = 3'd3,
        ST_PIPETHR = 3'd4,
        ST_NOTSEL  = 3'd5
    } stall_e;

    localparam int CODE_W = 3;
    localparam int FIELD_W = 2;

    // Dependency check result: which blocking reason applies, if any
    function automatic stall_e dep_reason(input dep_e d);
        case (d)
            DP_READY: return ST_NONE;
            DP_SHORT: return ST_SHORT;
            default:  return ST_LONG;
        endcase
    endfunction

endpackage

// File: rtl/ws_pipe_timer.sv
`timescale 1ns/1ps
module ws_pipe_timer
    #(parameter int INTERVAL = 4)
(
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic busy
);
    localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) + 1 : 1;
    localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (fire)
            cnt_q <= RELOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    // R4, R10: the issue logic must never fire into a pipe still counting down
    p_fire_idle_r4: assert property (@(posedge clk) disable iff (rst)
        fire |-> !busy);

    // R4, R10: a countdown only starts because an instruction was issued
    p_busy_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(fire));

endmodule

// File: rtl/ws_elig_unit.sv
`timescale 1ns/1ps
module ws_elig_unit
    import warp_sched_pkg::*;
(
    input  logic               active,
    input  dep_e               dep,
    input  cls_e               cls,
    input  logic [NUM_CLS-1:0] pipe_busy,
    input  logic               mem_full,
    output logic               eligible,
    output stall_e             block_code
);
    always_comb begin
        eligible   = 1'b0;
        block_code = ST_NONE;
        if (!active) begin
            block_code = ST_NONE;                   // R9
        end else if (dep != DP_READY) begin
            block_code = dep_reason(dep);           // R3
        end else if (cls == CL_MEM && mem_full) begin
            block_code = ST_MEMTHR;                 // R6
        end else if (pipe_busy[cls]) begin
            block_code = ST_PIPETHR;                // R4, R5, R10
        end else begin
            eligible = 1'b1;
        end
    end
endmodule

// File: rtl/ws_rr_pick.sv
`timescale 1ns/1ps
module ws_rr_pick
    #(parameter int N = 16,
      localparam int IW = (N > 1) ? $clog2(N) : 1)
(
    input  logic [N-1:0]  elig,
    input  logic [IW-1:0] last,
    output logic          pick_valid,
    output logic [IW-1:0] pick_idx,
    output logic [N-1:0]  pick_onehot
);
    always_comb begin
        pick_valid  = 1'b0;
        pick_idx    = '0;
        // R8: scan starting one past the last grant, wrapping around
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (int'(last) + k) % N;
            if (!pick_valid && elig[c]) begin
                pick_valid = 1'b1;
                pick_idx   = IW'(c);
            end
        end
        pick_onehot = '0;
        if (pick_valid)
            pick_onehot[pick_idx] = 1'b1;
    end
endmodule

// File: rtl/warp_issue_sched.sv
`timescale 1ns/1ps
module warp_issue_sched
    import warp_sched_pkg::*;
    #(parameter int NUM_WARPS    = 16,
      parameter int SFU_INTERVAL = 4,
      parameter int DP_INTERVAL  = 2)
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_WARPS-1:0]          warp_active,
    input  logic [FIELD_W*NUM_WARPS-1:0]  warp_dep,
    input  logic [FIELD_W*NUM_WARPS-1:0]  warp_cls,
    input  logic                          mem_q_full,
    input  logic                          fma_pipe_busy,
    output logic [NUM_WARPS-1:0]          issue_grant,
    output logic [CODE_W*NUM_WARPS-1:0]   stall_code
);
    localparam int IW = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1;
    localparam logic [IW-1:0] LAST_INIT = IW'(NUM_WARPS - 1);

    cls_e               wcls      [NUM_WARPS];
    logic [NUM_WARPS-1:0] elig;
    stall_e             blk_code  [NUM_WARPS];
    stall_e             next_code [NUM_WARPS];
    stall_e             code_q    [NUM_WARPS];
    logic [NUM_CLS-1:0] pipe_busy;

    logic               pick_valid;
    logic [IW-1:0]      pick_idx;
    logic [NUM_WARPS-1:0] pick_onehot;
    cls_e               pick_cls;

    logic [IW-1:0]        last_q;
    logic [NUM_WARPS-1:0] grant_q;

    // Per-warp eligibility and blocking reason
    for (genvar i = 0; i < NUM_WARPS; i++) begin : g_warp
        assign wcls[i] = cls_e'(warp_cls[FIELD_W*i +: FIELD_W]);

        ws_elig_unit u_elig (
            .active     (warp_active[i]),
            .dep        (dep_e'(warp_dep[FIELD_W*i +: FIELD_W])),
            .cls        (wcls[i]),
            .pipe_busy  (pipe_busy),
            .mem_full   (mem_q_full),
            .eligible   (elig[i]),
            .block_code (blk_code[i])
        );

        // R7: eligible losers are reported as not selected
        always_comb begin
            if (pick_onehot[i])
                next_code[i] = ST_NONE;
            else if (elig[i])
                next_code[i] = ST_NOTSEL;
            else
                next_code[i] = blk_code[i];
        end

        assign stall_code[CODE_W*i +: CODE_W] = code_q[i];

        // R2, R7: a granted warp carries no stall reason
        p_grant_clean_r7: assert property (@(posedge clk) disable iff (rst)
            issue_grant[i] |-> (stall_code[CODE_W*i +: CODE_W] == ST_NONE));

        // R7: "not selected" only when some other warp was granted
        p_notsel_has_winner_r7: assert property (@(posedge clk) disable iff (rst)
            (stall_code[CODE_W*i +: CODE_W] == ST_NOTSEL) |-> (|issue_grant));

        // R3: a grant always follows a ready dependency field
        p_grant_ready_r3: assert property (@(posedge clk) disable iff (rst)
            issue_grant[i] |-> ($past(warp_dep[FIELD_W*i +: FIELD_W]) == DP_READY));

        // R9: a grant always follows an active slot
        p_grant_active_r9: assert property (@(posedge clk) disable iff (rst)
            issue_grant[i] |-> $past(warp_active[i]));
    end

    // Per-class pipe occupancy: external flag, none, or local countdown
    for (genvar c = 0; c < NUM_CLS; c++) begin : g_pipe
        if (c == int'(CL_FMA)) begin : g_ext
            assign pipe_busy[c] = fma_pipe_busy;
        end else if (c == int'(CL_MEM)) begin : g_queue
            assign pipe_busy[c] = 1'b0;
        end else begin : g_timer
            localparam int IVL = (c == int'(CL_SFU)) ? SFU_INTERVAL : DP_INTERVAL;
            ws_pipe_timer #(.INTERVAL(IVL)) u_timer (
                .clk  (clk),
                .rst  (rst),
                .fire (pick_valid && (pick_cls == cls_e'(c))),
                .busy (pipe_busy[c])
            );
        end
    end

    ws_rr_pick #(.N(NUM_WARPS)) u_pick (
        .elig        (elig),
        .last        (last_q),
        .pick_valid  (pick_valid),
        .pick_idx    (pick_idx),
        .pick_onehot (pick_onehot)
    );

    assign pick_cls = wcls[pick_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
            last_q  <= LAST_INIT;
            for (int i = 0; i < NUM_WARPS; i++)
                code_q[i] <= ST_NONE;
        end else begin
            grant_q <= pick_onehot;
            if (pick_valid)
                last_q <= pick_idx;
            for (int i = 0; i < NUM_WARPS; i++)
                code_q[i] <= next_code[i];
        end
    end

    assign issue_grant = grant_q;

    // R2: never more than one grant per cycle
    p_single_grant_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(issue_grant));

    // R6: no memory instruction leaves while the request queue is full
    p_mem_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (pick_valid && pick_cls == CL_MEM) |-> !mem_q_full);

    // R5: the FP32 pipe is not fed while it reports busy
    p_fma_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (pick_valid && pick_cls == CL_FMA) |-> !fma_pipe_busy);

endmodule

// File: tb/sim_warp_issue_sched.sv
`timescale 1ns/1ps
module sim_warp_issue_sched;
    localparam int NW = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NW-1:0]   warp_active = '0;
    logic [2*NW-1:0] warp_dep = '0;
    logic [2*NW-1:0] warp_cls = '0;
    logic            mem_q_full = 1'b0;
    logic            fma_pipe_busy = 1'b0;
    logic [NW-1:0]   issue_grant;
    logic [3*NW-1:0] stall_code;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    warp_issue_sched u0 (
        .clk(clk), .rst(rst),
        .warp_active(warp_active), .warp_dep(warp_dep), .warp_cls(warp_cls),
        .mem_q_full(mem_q_full), .fma_pipe_busy(fma_pipe_busy),
        .issue_grant(issue_grant), .stall_code(stall_code)
    );

    // Vector: warps 0..3 only, one hex digit per warp (w3 w2 w1 w0)
    typedef struct packed {
        logic [3:0]  act;
        logic [15:0] dep;
        logic [15:0] cls;
        logic        mf;
        logic        fb;
        logic [3:0]  grant;
        logic [15:0] code;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{4'hF, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'h1, 16'h5550}, // R8 first pick w0
        '{4'hF, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'h2, 16'h5505}, // R8 advance
        '{4'hF, 16'h0100, 16'h0000, 1'b0, 1'b0, 4'h8, 16'h0155}, // R3 short skip
        '{4'hF, 16'h2000, 16'h0000, 1'b0, 1'b1, 4'h0, 16'h2444}, // R5 + R3 long
        '{4'hF, 16'h0000, 16'h0312, 1'b1, 1'b0, 4'h2, 16'h5503}, // R6 queue full
        '{4'hF, 16'h0000, 16'h0312, 1'b1, 1'b0, 4'h4, 16'h5043}, // R4 sfu busy
        '{4'hF, 16'h0000, 16'h0312, 1'b1, 1'b0, 4'h8, 16'h0443}, // R10 dp busy
        '{4'hF, 16'h0000, 16'h0312, 1'b0, 1'b0, 4'h1, 16'h5540}, // R6 queue free
        '{4'hF, 16'h0000, 16'h0312, 1'b0, 1'b0, 4'h2, 16'h5505}, // R4 sfu reopens
        '{4'h5, 16'h0000, 16'h0312, 1'b0, 1'b0, 4'h4, 16'h0005}, // R9 inactive
        '{4'h0, 16'h0000, 16'h0312, 1'b0, 1'b0, 4'h0, 16'h0000}  // R9 all idle
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1:    return "R8";
            2:       return "R3";
            3:       return "R5";
            4, 7:    return "R6";
            5, 8:    return "R4";
            6:       return "R10";
            default: return "R9";
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check_grant(input string tag, input logic [NW-1:0] exp);
        checks++;
        if (issue_grant !== exp) begin
            fails++;
            $display("FAIL %s grant actual=%h expected=%h", tag, issue_grant, exp);
        end
    endtask

    task automatic check_codes(input string tag, input logic [3*NW-1:0] exp);
        checks++;
        if (stall_code !== exp) begin
            fails++;
            $display("FAIL %s codes actual=%h expected=%h", tag, stall_code, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        rst = 1'b0;
    endtask

    initial begin
        #1_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: outputs cleared while reset is held
        warp_active = '1;
        step();
        step();
        check_grant("R1", '0);
        check_codes("R1", '0);
        rst = 1'b0;

        // Table walk
        for (int v = 0; v < NV; v++) begin
            logic [3*NW-1:0] ec;
            ec = '0;
            warp_active = '0;
            warp_dep = '0;
            warp_cls = '0;
            for (int w = 0; w < 4; w++) begin
                warp_active[w]     = VECS[v].act[w];
                warp_dep[2*w +: 2] = VECS[v].dep[4*w +: 2];
                warp_cls[2*w +: 2] = VECS[v].cls[4*w +: 2];
                ec[3*w +: 3]       = VECS[v].code[4*w +: 3];
            end
            mem_q_full    = VECS[v].mf;
            fma_pipe_busy = VECS[v].fb;
            step();
            check_grant(vec_tag(v), {12'h000, VECS[v].grant});
            check_codes(vec_tag(v), ec);
        end

        // R1, R8: mid-run reset restores pointer; full pool wraps 15 -> 0
        do_reset();
        check_grant("R1", '0);
        check_codes("R1", '0);
        warp_active = '1;
        warp_dep = '0;
        warp_cls = '0;
        mem_q_full = 1'b0;
        fma_pipe_busy = 1'b0;
        for (int k = 0; k <= NW; k++) begin
            logic [3*NW-1:0] ec;
            int wi;
            wi = k % NW;
            ec = '0;
            for (int w = 0; w < NW; w++)
                ec[3*w +: 3] = (w == wi) ? 3'd0 : 3'd5;
            step();
            check_grant("R8", NW'(1) << wi);
            check_codes("R7", ec);
        end

        // R4: lone special-function warp issues every 4 cycles
        do_reset();
        warp_active = 16'h0001;
        warp_cls = '0;
        warp_cls[1:0] = 2'd1;
        for (int k = 0; k < 9; k++) begin
            step();
            check_grant("R4", (k % 4 == 0) ? 16'h0001 : 16'h0000);
            check_codes("R4", (k % 4 == 0) ? 48'd0 : 48'd4);
        end

        // R10: lone double-precision warp issues every 2 cycles
        do_reset();
        warp_cls[1:0] = 2'd3;
        for (int k = 0; k < 5; k++) begin
            step();
            check_grant("R10", (k % 2 == 0) ? 16'h0001 : 16'h0000);
            check_codes("R10", (k % 2 == 0) ? 48'd0 : 48'd4);
        end

        // R6: memory warp ignores the FP32 busy flag
        do_reset();
        warp_cls[1:0] = 2'd2;
        fma_pipe_busy = 1'b1;
        step();
        check_grant("R6", 16'h0001);
        // R3: dependency code 3 counts as long
        warp_dep[1:0] = 2'd3;
        step();
        check_codes("R3", 48'd2);
        check_grant("R3", 16'h0000);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule